// File: doc/BRIEF.md
# Clocked Serial Byte Transmitter with Automatic Clock Hold

This block is the send half of a clocked serial link. Firmware places one byte at a time in a single holding register. The block moves that byte into a shift register and sends it most significant bit first on a data line. The bit clock has one of two sources:

- **Internal source.** The block divides its own system clock and drives the bit clock out.
- **External source.** A peer supplies the bit clock, and the block passes it through a two-stage synchroniser.

Data changes after each falling bit-clock edge and is held through the following rising edge, where the receiver samples it. The bit clock rests at high level.

When the holding register is refilled before the current byte ends, bytes follow one another with no gap. When it is not refilled, behaviour depends on the clock source:

- **Internal source.** The block holds the clock high and waits for the next write.
- **External source.** The peer keeps clocking, so the block sends an all-ones byte and raises a sticky error flag.

A single-cycle interrupt pulse marks each refill opportunity and each error. Transmission can be stopped in two ways:

- **Gentle stop.** Dropping the enable bit lets the current byte finish.
- **Abort.** Setting the inhibit bit ends everything at once and clears the block's state.

Top module: `sync_ser_tx`

## Requirements
- R1: Each byte leaves on `sdo` most significant bit first, eight bits per byte. Each bit is placed after a falling edge of the bit clock and is held through the next rising edge. The bit clock rests high.
- R2: A data write makes `buf_empty` 0 on the next cycle. When the held byte moves into the shifter, `buf_empty` becomes 1 and `irq` is high for exactly one system clock.
- R3: With the internal clock, when a new byte is written before the current byte ends, the first rising edge of the new byte comes exactly DIV system clocks after the last rising edge of the previous byte.
- R4: With the internal clock and no new byte at the end of a transfer, the block holds `sck_out` high with `busy`=1 and `shifting`=0. After a data write, `sck_out` falls within DIV system clocks.
- R5: `ctrl_in` bit 2 selects the external clock. It is taken only while `busy`=0. In external mode `sck_out` stays high, and each byte starts at a falling edge of `sck_in` with the held byte.
- R6: In external mode, a falling `sck_in` edge that starts a byte while `buf_empty`=1 is an underrun. It sets `underrun`, pulses `irq`, and sends the byte 8'hFF.
- R7: `underrun` stays set until a `stat_rd` pulse or an inhibit. An underrun in the same cycle as `stat_rd` leaves it set.
- R8: `ctrl_in` bit 0 is enable. Clearing it lets the byte in flight finish. After that, `busy`=0, `sdo`=1, `sck_out`=1, and no further byte starts.
- R9: A control write with `ctrl_in` bit 1 (inhibit) set does the following on the next cycle: forces `busy`, `shifting` and `underrun` to 0, sets `buf_empty` to 1, sets `sck_out` and `sdo` to 1, and clears enable. A data write in the same cycle is dropped.
- R10: After reset: `sck_out`=1, `sdo`=1, `buf_empty`=1, `busy`=0, `shifting`=0, `underrun`=0, `irq`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| data_wr | input | 1 | Write strobe for the holding register |
| data_in | input | DW | Byte to send |
| ctrl_wr | input | 1 | Write strobe for the control bits |
| ctrl_in | input | 3 | Control bits: bit 0 enable, bit 1 inhibit, bit 2 external clock |
| stat_rd | input | 1 | Status read pulse; clears the error flag |
| sck_in | input | 1 | External bit clock |
| sck_out | output | 1 | Internally generated bit clock, high when resting |
| sdo | output | 1 | Serial data out |
| buf_empty | output | 1 | Holding register may be written |
| busy | output | 1 | Transfer session active |
| shifting | output | 1 | A byte is being shifted |
| underrun | output | 1 | Sticky underrun error |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
An abort and a data write can arrive in the same system clock. The bench provokes this by starting an external-mode byte with an empty register, so that the error flag is set. It then raises inhibit and a data strobe on the same edge. Afterwards it checks that the flags and lines are cleared and that `buf_empty` is still 1. It then re-enables the block in internal mode and watches `sck_out` stay high for many bit periods, which proves the written byte was discarded.

// File: rtl/sst_pkg.sv
package sst_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_SHIFT = 2'd2
    } sst_state_e;

    localparam int CTL_EN  = 0;
    localparam int CTL_INH = 1;
    localparam int CTL_EXT = 2;
    localparam int CTL_W   = 3;
endpackage

// File: rtl/sst_edge_sync.sv
module sst_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] sh_q, sh_d;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
    assign fall = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/sst_phase_timer.sv
module sst_phase_timer #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_q, cnt_d;

    assign tick = run && (cnt_q == LAST);

    always_comb begin
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sync_ser_tx.sv
module sync_ser_tx
    import sst_pkg::*;
#(
    parameter int DW          = 8,
    parameter int DIV         = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_wr,
    input  logic [DW-1:0]     data_in,
    input  logic              ctrl_wr,
    input  logic [CTL_W-1:0]  ctrl_in,
    input  logic              stat_rd,
    input  logic              sck_in,
    output logic              sck_out,
    output logic              sdo,
    output logic              buf_empty,
    output logic              busy,
    output logic              shifting,
    output logic              underrun,
    output logic              irq
);
    localparam int HALF = DIV / 2;
    localparam int BW   = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [BW-1:0] LAST_BIT = BW'(DW - 1);

    typedef struct packed {
        sst_state_e    st;
        logic [DW-1:0] sr;
        logic [BW-1:0] bidx;
        logic [DW-1:0] tbuf;
        logic          empty;
        logic          en;
        logic          inh;
        logic          ext;
        logic          busy;
        logic          shf;
        logic          err;
        logic          irq;
        logic          sck;
        logic          sdo;
    } regs_t;

    regs_t q, d;
    logic  tick, ext_rise, ext_fall;
    logic  inh_now, do_load, do_under, byte_end;

    sst_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (sck_in),
        .rise (ext_rise),
        .fall (ext_fall)
    );

    sst_phase_timer #(.HALF(HALF)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  ((q.st == ST_SHIFT) && !q.ext),
        .tick (tick)
    );

    always_comb begin
        d        = q;
        d.irq    = 1'b0;
        inh_now  = ctrl_wr && ctrl_in[CTL_INH];
        do_load  = 1'b0;
        do_under = 1'b0;
        byte_end = 1'b0;

        if (ctrl_wr) begin
            d.en  = ctrl_in[CTL_EN] && !ctrl_in[CTL_INH];
            d.inh = ctrl_in[CTL_INH];
            if (!q.busy) d.ext = ctrl_in[CTL_EXT];
        end
        if (stat_rd) d.err = 1'b0;

        case (q.st)
            ST_IDLE: begin
                if (d.en) begin
                    d.st   = ST_WAIT;
                    d.busy = 1'b1;
                end
            end
            ST_WAIT: begin
                if (!d.en) begin
                    d.st   = ST_IDLE;
                    d.busy = 1'b0;
                end else if (!q.ext) begin
                    do_load = !q.empty;
                end else if (ext_fall) begin
                    do_load  = !q.empty;
                    do_under = q.empty;
                end
            end
            ST_SHIFT: begin
                if (!q.ext) begin
                    if (tick) begin
                        if (!q.sck) begin
                            d.sck = 1'b1;
                        end else if (q.bidx != LAST_BIT) begin
                            d.sr   = {q.sr[DW-2:0], 1'b1};
                            d.sdo  = q.sr[DW-2];
                            d.bidx = q.bidx + 1'b1;
                            d.sck  = 1'b0;
                        end else begin
                            byte_end = 1'b1;
                        end
                    end
                end else begin
                    if (ext_fall && (q.bidx != LAST_BIT)) begin
                        d.sr   = {q.sr[DW-2:0], 1'b1};
                        d.sdo  = q.sr[DW-2];
                        d.bidx = q.bidx + 1'b1;
                    end else if (ext_rise && (q.bidx == LAST_BIT)) begin
                        byte_end = 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (byte_end) begin
            d.shf = 1'b0;
            d.sdo = 1'b1;
            if (!d.en) begin
                d.st   = ST_IDLE;
                d.busy = 1'b0;
            end else if (!q.ext && !q.empty) begin
                do_load = 1'b1;
            end else begin
                d.st = ST_WAIT;
            end
        end

        if (do_load) begin
            d.st    = ST_SHIFT;
            d.sr    = q.tbuf;
            d.sdo   = q.tbuf[DW-1];
            d.bidx  = '0;
            d.empty = 1'b1;
            d.irq   = 1'b1;
            d.shf   = 1'b1;
            d.sck   = q.ext;
        end
        if (do_under) begin
            d.st   = ST_SHIFT;
            d.sr   = '1;
            d.sdo  = 1'b1;
            d.bidx = '0;
            d.err  = 1'b1;
            d.irq  = 1'b1;
            d.shf  = 1'b1;
        end

        if (data_wr && !inh_now && !q.inh) begin
            d.tbuf  = data_in;
            d.empty = 1'b0;
        end

        if (inh_now || d.inh) begin
            d.st    = ST_IDLE;
            d.bidx  = '0;
            d.tbuf  = '0;
            d.empty = 1'b1;
            d.en    = 1'b0;
            d.busy  = 1'b0;
            d.shf   = 1'b0;
            d.err   = 1'b0;
            d.irq   = 1'b0;
            d.sck   = 1'b1;
            d.sdo   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, sr: '1, bidx: '0, tbuf: '0, empty: 1'b1,
                   en: 1'b0, inh: 1'b0, ext: 1'b0, busy: 1'b0, shf: 1'b0,
                   err: 1'b0, irq: 1'b0, sck: 1'b1, sdo: 1'b1};
        end else begin
            q <= d;
        end
    end

    assign sck_out   = q.sck;
    assign sdo       = q.sdo;
    assign buf_empty = q.empty;
    assign busy      = q.busy;
    assign shifting  = q.shf;
    assign underrun  = q.err;
    assign irq       = q.irq;

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R2
    AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr && !(ctrl_wr && ctrl_in[CTL_INH]) && !q.inh |=> !buf_empty); // R2
    AST_WAIT_HOLDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WAIT) |-> sck_out); // R4
    AST_EXT_NO_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        q.ext |-> sck_out); // R5
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        underrun && !stat_rd && !(ctrl_wr && ctrl_in[CTL_INH]) |=> underrun); // R7
    AST_IDLE_LINES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sdo && sck_out)); // R8
    AST_SHIFT_IN_SESSION: assert property (@(posedge clk) disable iff (!rst_n)
        shifting |-> busy); // R8
    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr && ctrl_in[CTL_INH] |=>
            (!busy && !shifting && !underrun && buf_empty && sck_out && sdo)); // R9
endmodule

// File: tb/sync_ser_tx_bench.sv
module sync_ser_tx_bench;
    localparam int DW  = 8;
    localparam int DIV = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          data_wr = 1'b0;
    logic [DW-1:0] data_in = '0;
    logic          ctrl_wr = 1'b0;
    logic [2:0]    ctrl_in = '0;
    logic          stat_rd = 1'b0;
    logic          sck_in = 1'b1;
    logic          sck_out, sdo, buf_empty, busy, shifting, underrun, irq;

    int nchk = 0;
    int nerr = 0;

    always #4 clk = ~clk;

    sync_ser_tx #(.DW(DW), .DIV(DIV), .SYNC_STAGES(2)) u_sync_ser_tx (
        .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .data_in(data_in),
        .ctrl_wr(ctrl_wr), .ctrl_in(ctrl_in), .stat_rd(stat_rd),
        .sck_in(sck_in), .sck_out(sck_out), .sdo(sdo),
        .buf_empty(buf_empty), .busy(busy), .shifting(shifting),
        .underrun(underrun), .irq(irq)
    );

    // Slave-side sampler on the internal clock, plus interrupt bookkeeping.
    logic [7:0] rx [0:7];
    int         gaps [0:7];
    int         rx_n = 0, nbit = 0, cyc = 0, last_rise = 0;
    int         irq_cnt = 0, irq_wide = 0;
    logic [7:0] acc = '0;
    logic       sck_prev = 1'b1, irq_prev = 1'b0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (irq) irq_cnt = irq_cnt + 1;
        if (irq && irq_prev) irq_wide = irq_wide + 1;
        irq_prev = irq;
        if (rst_n && sck_out && !sck_prev) begin
            if (nbit == 0 && rx_n < 8) gaps[rx_n] = cyc - last_rise;
            last_rise = cyc;
            acc = {acc[6:0], sdo};
            nbit = nbit + 1;
            if (nbit == 8) begin
                if (rx_n < 8) rx[rx_n] = acc;
                rx_n = rx_n + 1;
                nbit = 0;
            end
        end
        sck_prev = sck_out;
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: got %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic wr_data(input logic [7:0] v);
        data_wr = 1'b1; data_in = v;
        tick();
        data_wr = 1'b0;
    endtask

    task automatic wr_ctrl(input logic [2:0] v);
        ctrl_wr = 1'b1; ctrl_in = v;
        tick();
        ctrl_wr = 1'b0;
    endtask

    task automatic ext_byte(output logic [7:0] got);
        got = '0;
        for (int b = 0; b < 8; b++) begin
            sck_in = 1'b0;
            repeat (8) tick();
            got = {got[6:0], sdo};
            sck_in = 1'b1;
            repeat (8) tick();
        end
    endtask

    task automatic t_reset();
        chk("R10 sck_out", 32'(sck_out), 1);
        chk("R10 sdo", 32'(sdo), 1);
        chk("R10 buf_empty", 32'(buf_empty), 1);
        chk("R10 busy", 32'(busy), 0);
        chk("R10 shifting", 32'(shifting), 0);
        chk("R10 underrun", 32'(underrun), 0);
        chk("R10 irq", 32'(irq), 0);
    endtask

    task automatic t_internal();
        int n;
        logic hi_ok;
        wr_data(8'hB4);
        chk("R2 write clears empty", 32'(buf_empty), 0);
        wr_ctrl(3'b001);
        for (int i = 0; i < 50 && !buf_empty; i++) tick();
        chk("R2 empty after load", 32'(buf_empty), 1);
        chk("R2 one irq on load", 32'(irq_cnt), 1);
        wr_data(8'h3C);
        for (int i = 0; i < 400 && rx_n < 2; i++) tick();
        chk("R1 first byte", 32'(rx[0]), 32'h0B4);
        chk("R1 second byte", 32'(rx[1]), 32'h03C);
        chk("R3 back-to-back spacing", 32'(gaps[1]), DIV);
        repeat (2 * DIV) tick();
        hi_ok = 1'b1;
        for (int i = 0; i < 3 * DIV; i++) begin
            if (!sck_out) hi_ok = 1'b0;
            tick();
        end
        chk("R4 clock held high", 32'(hi_ok), 1);
        chk("R4 busy in wait", 32'(busy), 1);
        chk("R4 not shifting in wait", 32'(shifting), 0);
        wr_data(8'h81);
        n = 0;
        while (sck_out && n < 4 * DIV) begin tick(); n++; end
        chk("R4 resume within one period", 32'(n >= 1 && n <= DIV), 1);
        wr_ctrl(3'b000);
        for (int i = 0; i < 400 && busy; i++) tick();
        chk("R8 last byte completes", 32'(rx[2]), 32'h081);
        chk("R8 byte count", 32'(rx_n), 3);
        chk("R8 busy cleared", 32'(busy), 0);
        chk("R8 sdo high", 32'(sdo), 1);
        chk("R8 sck high", 32'(sck_out), 1);
        chk("R2 irq count", 32'(irq_cnt), 3);
        chk("R2 irq width", 32'(irq_wide), 0);
    endtask

    task automatic t_external();
        logic [7:0] got;
        int base;
        wr_data(8'h96);
        wr_ctrl(3'b101);
        base = irq_cnt;
        ext_byte(got);
        chk("R5 external byte", 32'(got), 32'h096);
        chk("R5 sck_out stays high", 32'(sck_out), 1);
        chk("R5 load irq", 32'(irq_cnt - base), 1);
        chk("R5 empty after load", 32'(buf_empty), 1);
        chk("R6 no error yet", 32'(underrun), 0);
        ext_byte(got);
        chk("R6 underrun byte", 32'(got), 32'h0FF);
        chk("R6 error set", 32'(underrun), 1);
        chk("R6 error irq", 32'(irq_cnt - base), 2);
        wr_ctrl(3'b100);
        repeat (4) tick();
        chk("R8 stop in wait", 32'(busy), 0);
        repeat (20) tick();
        chk("R7 error sticky", 32'(underrun), 1);
        stat_rd = 1'b1; tick(); stat_rd = 1'b0;
        chk("R7 read clears error", 32'(underrun), 0);
        ext_byte(got);
        chk("R8 no byte after stop", 32'(irq_cnt - base), 2);
        chk("R8 no error after stop", 32'(underrun), 0);
        chk("R8 no shifting after stop", 32'(shifting), 0);
    endtask

    task automatic t_inhibit();
        logic hi_ok;
        wr_ctrl(3'b101);
        sck_in = 1'b0;
        repeat (6) tick();
        chk("R6 underrun before abort", 32'(underrun), 1);
        ctrl_wr = 1'b1; ctrl_in = 3'b010;
        data_wr = 1'b1; data_in = 8'h5A;
        tick();
        ctrl_wr = 1'b0; data_wr = 1'b0;
        chk("R9 busy", 32'(busy), 0);
        chk("R9 shifting", 32'(shifting), 0);
        chk("R9 underrun", 32'(underrun), 0);
        chk("R9 buf_empty", 32'(buf_empty), 1);
        chk("R9 sdo", 32'(sdo), 1);
        chk("R9 sck_out", 32'(sck_out), 1);
        sck_in = 1'b1;
        repeat (8) tick();
        wr_ctrl(3'b001);
        hi_ok = 1'b1;
        for (int i = 0; i < 5 * DIV; i++) begin
            if (!sck_out) hi_ok = 1'b0;
            tick();
        end
        chk("R9 dropped write never sent", 32'(hi_ok), 1);
        chk("R9 buffer still empty", 32'(buf_empty), 1);
        chk("R9 re-enabled waits", 32'(busy), 1);
        wr_ctrl(3'b000);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_internal();
        t_external();
        t_inhibit();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule